// File: doc/BRIEF.md
# Dual-Bank Weight Preload Buffer

This block keeps block-floating-point weights ready for a dot-product engine. It has two buffer sets, and each set holds two column slots. A slot stores one weight vector and the shared exponent that goes with it. Weight words and exponents arrive on two separate buses, and the block captures both on the same beat. Two independent load enables pick which set takes the beats. While either enable is high the full input bandwidth is used for loading, so compute is locked out.

A set is filled in two consecutive beats. The first beat fills column 2 and the second fills column 1. Filling both sets back to back therefore takes four beats. A bank select input chooses which set feeds the compute outputs. Each set has a full flag that rises once both of its columns hold fresh data. The flag drops when compute moves off that set. The usual sequence is: fill one set, fill the other, drop both enables, compute from the selected set, then swap sets and refill the released one.

Top module: `wbuf_dual_bank`

## Requirements
- R1: A load beat stores the weight bus and the exponent bus together into one slot, and the stored values are visible at the outputs in the cycle after the beat.
- R2: The first beat after a set's load enable rises, whether from idle, after a clash, or after a beat into the other set, writes column 2 (index 1). The next consecutive beat into the same set writes column 1 (index 0).
- R3: With only `ld_first` high, beats go into set 0. With only `ld_second` high, beats go into set 1.
- R4: When both load enables are high in the same cycle, `load_err` is high in that cycle and no slot of either set changes.
- R5: `compute_ok` is low in every cycle where either load enable is high, and high otherwise.
- R6: With `bank_sel` low the outputs show set 0. With it high they show set 1. The choice follows `bank_sel` in the same cycle.
- R7: `set_full[s]` (bit s for set s) goes high in the cycle after the second beat of an uninterrupted two-beat fill of set s.
- R8: When `bank_sel` moves away from set s, and set s is not being loaded in that cycle, `set_full[s]` is low from the next cycle on.
- R9: A partial fill (a single beat followed by idle) leaves that set's full flag low, and the next fill of that set starts again at column 2.
- R10: After reset all slots read zero, both full flags are low, `load_err` is low and `compute_ok` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_first | input | 1 | Load enable for set 0 |
| ld_second | input | 1 | Load enable for set 1 |
| bank_sel | input | 1 | Active set for compute: 0 selects set 0, 1 selects set 1 |
| wt_in | input | W_WIDTH (80) | Weight word of the current load beat |
| exp_in | input | E_WIDTH (8) | Shared exponent of the current load beat |
| act_wt_c1 | output | W_WIDTH (80) | Column 1 weights of the active set |
| act_wt_c2 | output | W_WIDTH (80) | Column 2 weights of the active set |
| act_exp_c1 | output | E_WIDTH (8) | Column 1 exponent of the active set |
| act_exp_c2 | output | E_WIDTH (8) | Column 2 exponent of the active set |
| compute_ok | output | 1 | High when compute may be issued (no preload in progress) |
| load_err | output | 1 | Both load enables are high in this cycle |
| set_full | output | 2 | Per-set full flag, bit s for set s |

## Verification
The bench builds the block with its default widths of 80-bit weights and 8-bit exponents. Every test word has distinct bits above bit 63, so a slot that is truncated, a column that is swapped, or a bank that is crossed all show up as a mismatch. The directed sequences cover a back-to-back four-beat fill, a clash cycle, a partial fill followed by a restart, and a switch from one set to the other in the middle of a fill. Together these reach the column pointer restart and the release path of each full flag.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    localparam int NUM_SETS = 2;
    localparam int NUM_COLS = 2;

    typedef enum logic {
        COL_ONE = 1'b0,
        COL_TWO = 1'b1
    } col_e;

    typedef enum logic [1:0] {
        LD_IDLE,
        LD_SET0,
        LD_SET1,
        LD_CLASH
    } ld_e;

    typedef struct packed {
        logic valid;
        logic set;
        col_e col;
    } beat_t;

    function automatic ld_e decode_ld(input logic en_a, input logic en_b);
        case ({en_a, en_b})
            2'b10:   return LD_SET0;
            2'b01:   return LD_SET1;
            2'b11:   return LD_CLASH;
            default: return LD_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/wbuf_load_ctrl.sv
module wbuf_load_ctrl
    import wbuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en_a,
    input  logic  en_b,
    output beat_t beat,
    output logic  clash
);

    ld_e  mode;
    logic prev_valid;
    logic prev_set;
    col_e ptr_q;
    logic continuing;

    always_comb begin
        mode       = decode_ld(en_a, en_b);
        clash      = (mode == LD_CLASH);
        beat.valid = (mode == LD_SET0) || (mode == LD_SET1);
        beat.set   = (mode == LD_SET1);
        continuing = prev_valid && (prev_set == beat.set);
        beat.col   = continuing ? ptr_q : COL_TWO;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_valid <= 1'b0;
            prev_set   <= 1'b0;
            ptr_q      <= COL_TWO;
        end else begin
            prev_valid <= beat.valid;
            prev_set   <= beat.set;
            ptr_q      <= beat.valid ? col_e'(~beat.col) : COL_TWO;
        end
    end

endmodule

// File: rtl/wbuf_bank.sv
module wbuf_bank
    import wbuf_pkg::*;
#(
    parameter int W_WIDTH = 80,
    parameter int E_WIDTH = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  col_e                              wr_col,
    input  logic [W_WIDTH-1:0]                wt_in,
    input  logic [E_WIDTH-1:0]                exp_in,
    input  logic                              release_i,
    output logic [NUM_COLS-1:0][W_WIDTH-1:0]  wt_o,
    output logic [NUM_COLS-1:0][E_WIDTH-1:0]  exp_o,
    output logic                              full_o
);

    logic [NUM_COLS-1:0] written;

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        always_ff @(posedge clk) begin
            if (rst) begin
                wt_o[c]  <= '0;
                exp_o[c] <= '0;
            end else if (wr_en && (int'(wr_col) == c)) begin
                wt_o[c]  <= wt_in;
                exp_o[c] <= exp_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            written <= '0;
        end else if (wr_en) begin
            if (wr_col == COL_TWO) begin
                written <= 2'b10;
            end else begin
                written <= written | 2'b01;
            end
        end else if (release_i) begin
            written <= '0;
        end
    end

    assign full_o = &written;

endmodule

// File: rtl/wbuf_dual_bank.sv
module wbuf_dual_bank
    import wbuf_pkg::*;
#(
    parameter int W_WIDTH = 80,
    parameter int E_WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_first,
    input  logic               ld_second,
    input  logic               bank_sel,
    input  logic [W_WIDTH-1:0] wt_in,
    input  logic [E_WIDTH-1:0] exp_in,
    output logic [W_WIDTH-1:0] act_wt_c1,
    output logic [W_WIDTH-1:0] act_wt_c2,
    output logic [E_WIDTH-1:0] act_exp_c1,
    output logic [E_WIDTH-1:0] act_exp_c2,
    output logic               compute_ok,
    output logic               load_err,
    output logic [1:0]         set_full
);

    beat_t beat;
    logic  sel_q;

    logic [NUM_SETS-1:0][NUM_COLS-1:0][W_WIDTH-1:0] slot_wt;
    logic [NUM_SETS-1:0][NUM_COLS-1:0][E_WIDTH-1:0] slot_exp;

    wbuf_load_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .en_a  (ld_first),
        .en_b  (ld_second),
        .beat  (beat),
        .clash (load_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
        end else begin
            sel_q <= bank_sel;
        end
    end

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        logic wr_here;
        logic rel_here;

        assign wr_here  = beat.valid && (beat.set == s[0]);
        assign rel_here = (sel_q == s[0]) && (bank_sel != s[0]);

        wbuf_bank #(
            .W_WIDTH (W_WIDTH),
            .E_WIDTH (E_WIDTH)
        ) u_bank (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_here),
            .wr_col    (beat.col),
            .wt_in     (wt_in),
            .exp_in    (exp_in),
            .release_i (rel_here),
            .wt_o      (slot_wt[s]),
            .exp_o     (slot_exp[s]),
            .full_o    (set_full[s])
        );
    end

    always_comb begin
        act_wt_c1  = slot_wt[bank_sel][COL_ONE];
        act_wt_c2  = slot_wt[bank_sel][COL_TWO];
        act_exp_c1 = slot_exp[bank_sel][COL_ONE];
        act_exp_c2 = slot_exp[bank_sel][COL_TWO];
        compute_ok = !(ld_first || ld_second);
    end

endmodule

// File: rtl/wbuf_dual_bank_chk.sv
module wbuf_dual_bank_chk #(
    parameter int W_WIDTH = 80,
    parameter int E_WIDTH = 8
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           ld_first,
    input logic                           ld_second,
    input logic                           bank_sel,
    input logic [W_WIDTH-1:0]             wt_in,
    input logic [E_WIDTH-1:0]             exp_in,
    input logic                           compute_ok,
    input logic                           load_err,
    input logic [1:0]                     set_full,
    input logic [1:0][1:0][W_WIDTH-1:0]   slot_wt,
    input logic [1:0][1:0][E_WIDTH-1:0]   slot_exp
);

    AST_CLASH_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        load_err |=> ($stable(slot_wt) && $stable(slot_exp))); // R4

    AST_COMPUTE_LOCK: assert property (@(posedge clk) disable iff (rst)
        compute_ok |-> (!ld_first && !ld_second)); // R5

    AST_SET0_START_COL2: assert property (@(posedge clk) disable iff (rst)
        (ld_first && !ld_second && !$past(ld_first)) |=>
        (slot_wt[0][1] == $past(wt_in) && slot_exp[0][1] == $past(exp_in))); // R2

    AST_SET1_TARGET: assert property (@(posedge clk) disable iff (rst)
        (ld_second && !ld_first) |=>
        (slot_wt[1][0] == $past(wt_in) || slot_wt[1][1] == $past(wt_in))); // R3

    AST_SET0_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!$past(bank_sel) && bank_sel && !(ld_first && !ld_second)) |=> !set_full[0]); // R8

endmodule

bind wbuf_dual_bank wbuf_dual_bank_chk #(
    .W_WIDTH (W_WIDTH),
    .E_WIDTH (E_WIDTH)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ld_first   (ld_first),
    .ld_second  (ld_second),
    .bank_sel   (bank_sel),
    .wt_in      (wt_in),
    .exp_in     (exp_in),
    .compute_ok (compute_ok),
    .load_err   (load_err),
    .set_full   (set_full),
    .slot_wt    (slot_wt),
    .slot_exp   (slot_exp)
);

// File: tb/wbuf_dual_bank_test.sv
module wbuf_dual_bank_test;

    localparam int WW = 80;
    localparam int EW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          ld_first, ld_second, bank_sel;
    logic [WW-1:0] wt_in;
    logic [EW-1:0] exp_in;
    logic [WW-1:0] act_wt_c1, act_wt_c2;
    logic [EW-1:0] act_exp_c1, act_exp_c2;
    logic          compute_ok, load_err;
    logic [1:0]    set_full;

    int nchk  = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    wbuf_dual_bank #(.W_WIDTH(WW), .E_WIDTH(EW)) uut (
        .clk(clk), .rst(rst), .ld_first(ld_first), .ld_second(ld_second),
        .bank_sel(bank_sel), .wt_in(wt_in), .exp_in(exp_in),
        .act_wt_c1(act_wt_c1), .act_wt_c2(act_wt_c2),
        .act_exp_c1(act_exp_c1), .act_exp_c2(act_exp_c2),
        .compute_ok(compute_ok), .load_err(load_err), .set_full(set_full)
    );

    function automatic logic [WW-1:0] mkw(input int k);
        return {16'(k * 37 + 16'hC001), {4{16'(k * 101 + 7)}}};
    endfunction

    function automatic logic [EW-1:0] mke(input int k);
        return 8'(k * 13 + 3);
    endfunction

    task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] expv);
        nchk++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic chk_set(input string req, input int kc2, input int kc1);
        chk(req, act_wt_c2, mkw(kc2));
        chk(req, WW'(act_exp_c2), WW'(mke(kc2)));
        chk(req, act_wt_c1, mkw(kc1));
        chk(req, WW'(act_exp_c1), WW'(mke(kc1)));
    endtask

    task automatic do_beat(input logic a, input logic b, input int k);
        ld_first  = a;
        ld_second = b;
        wt_in     = mkw(k);
        exp_in    = mke(k);
        #1;
        chk("R5 compute_ok during load", WW'(compute_ok), WW'(1'b0));
        chk("R4 load_err", WW'(load_err), WW'(a & b));
        @(negedge clk);
    endtask

    task automatic idle();
        ld_first  = 1'b0;
        ld_second = 1'b0;
        #1;
        chk("R5 compute_ok idle", WW'(compute_ok), WW'(1'b1));
        @(negedge clk);
    endtask

    task automatic test_reset();
        chk("R10 wt c1", act_wt_c1, '0);
        chk("R10 wt c2", act_wt_c2, '0);
        chk("R10 exp", WW'({act_exp_c1, act_exp_c2}), '0);
        chk("R10 full", WW'(set_full), '0);
        chk("R10 load_err", WW'(load_err), '0);
        chk("R10 compute_ok", WW'(compute_ok), WW'(1'b1));
    endtask

    task automatic test_fill_both();
        do_beat(1'b1, 1'b0, 1);
        chk("R1 R2 R3 set0 col2 next cycle", act_wt_c2, mkw(1));
        chk("R1 set0 exp col2", WW'(act_exp_c2), WW'(mke(1)));
        chk("R7 not full after one beat", WW'(set_full), 2'b00);
        do_beat(1'b1, 1'b0, 2);
        chk("R7 set0 full", WW'(set_full), 2'b01);
        do_beat(1'b0, 1'b1, 3);
        do_beat(1'b0, 1'b1, 4);
        chk("R7 both full", WW'(set_full), 2'b11);
        idle();
        bank_sel = 1'b0;
        #1;
        chk_set("R6 R3 set0 view", 1, 2);
        bank_sel = 1'b1;
        #1;
        chk_set("R6 R3 set1 view", 3, 4);
        @(negedge clk);
        chk("R8 set0 released", WW'(set_full), 2'b10);
    endtask

    task automatic test_clash();
        do_beat(1'b1, 1'b1, 9);
        ld_first = 1'b0;
        ld_second = 1'b0;
        chk_set("R4 set1 unchanged", 3, 4);
        bank_sel = 1'b0;
        #1;
        chk_set("R4 set0 unchanged", 1, 2);
        @(negedge clk);
        chk("R8 set1 released", WW'(set_full), 2'b00);
    endtask

    task automatic test_partial();
        do_beat(1'b0, 1'b1, 5);
        idle();
        chk("R9 partial not full", WW'(set_full), 2'b00);
        do_beat(1'b0, 1'b1, 6);
        do_beat(1'b0, 1'b1, 7);
        idle();
        chk("R9 R7 refill full", WW'(set_full), 2'b10);
        bank_sel = 1'b1;
        #1;
        chk_set("R9 R2 restart at col2", 6, 7);
        @(negedge clk);
    endtask

    task automatic test_switch_mid();
        do_beat(1'b1, 1'b0, 10);
        do_beat(1'b0, 1'b1, 11);
        do_beat(1'b0, 1'b1, 12);
        idle();
        chk_set("R2 other set restarts at col2", 11, 12);
        chk("R9 R7 flags after switch", WW'(set_full), 2'b10);
        bank_sel = 1'b0;
        #1;
        chk_set("R2 R9 set0 partial keeps col1", 10, 2);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        ld_first = 1'b0;
        ld_second = 1'b0;
        bank_sel = 1'b0;
        wt_in = '0;
        exp_in = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        test_reset();
        @(negedge clk);
        test_fill_both();
        test_clash();
        test_partial();
        test_switch_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule